// File: doc/BRIEF.md
# LCD Display Update Sequencer

This block sits between the serial receiver that delivers a new frequency reading and a timed character-display driver. It waits until the receiver signals that a reading is complete. It then sends the driver a fixed run of four operations, one at a time: a cursor command that moves printing to the first column of the top line, then three characters that spell the musical note. The block never drives the display pins. Each operation is offered to the driver with a request and is held until the driver answers with done. The driver can therefore stay generic, with all of its own timing, while this block owns the order of the operations and the link to the serial side.

The note arrives from a combinational frequency-to-note converter as three fields: a letter code, a sharp flag and an octave number. At the start of each update the block captures these fields, so the text printed in one update always comes from a single reading. A new reading that lands while an update is running is remembered, and exactly one more update follows.

Top module: `lcd_update_seq`

## Requirements
- R1: While reset is active and after its release, `drv_req_o` is low until a data-ready pulse has been received.
- R2: When idle with no pending pulse, the block never raises `drv_req_o`.
- R3: An update sends four items in a fixed order. The first is a command (`drv_rs_o`=0) with value 0x80, which sets the cursor to column 0 of line 1. The three characters that follow all have `drv_rs_o`=1.
- R4: The second item is the note letter. Letter codes 0 to 6 give ASCII 'A' (0x41) plus the code. Code 7 gives '?' (0x3F).
- R5: The third item is '#' (0x23) when the sharp flag is set and a space (0x20) when it is clear.
- R6: The fourth item is the octave. Values 0 to 9 give ASCII '0' (0x30) plus the value. Values 10 to 15 give '?' (0x3F).
- R7: While `drv_req_o` is high and `drv_done_i` is low, `drv_req_o`, `drv_rs_o` and `drv_data_o` hold steady. After done is seen, `drv_req_o` is low for exactly one cycle, and the next item is then offered.
- R8: `drv_done_i` has no effect while `drv_req_o` is low.
- R9: A data-ready pulse that arrives during an update is remembered. Exactly one more full update starts one cycle after the last done, however many pulses arrived.
- R10: The note fields are captured when an update starts. Changes on the converter inputs during an update do not alter the characters it prints.
- R11: From idle, `drv_req_o` goes high right after the second rising edge that follows a data-ready pulse. The first edge samples the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| data_ready_i | input | 1 | One-cycle pulse: a new reading is available |
| note_letter_i | input | LETTER_W (3) | Converter letter code, 0..6 = A..G |
| note_sharp_i | input | 1 | Converter accidental flag |
| note_octave_i | input | OCT_W (4) | Converter octave number |
| drv_req_o | output | 1 | Item offered to the display driver |
| drv_rs_o | output | 1 | 0 = command, 1 = character data |
| drv_data_o | output | DATA_W (8) | Command or character byte |
| drv_done_i | input | 1 | Driver has finished the offered item |

## Verification
A wrong item index shows within one handshake as a misplaced byte or a wrong `drv_rs_o` value. The bench compares every offered item with its expected byte. A pending flag that is lost or stuck shows up at the ports: the extra update never comes, or a spurious one starts a single cycle after the last done. A snapshot that is not taken at the start of the update appears in the next character offered after the converter inputs change. An error in the gap or hold logic breaks the one-cycle low gap or the steady byte on the very next edge.

// File: rtl/lcd_seq_pkg.sv
`timescale 1ns/1ps
package lcd_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_GAP  = 2'd2
  } seq_state_e;

  // Item order is behaviour: cursor first, then letter, accidental, octave.
  typedef enum logic [1:0] {
    IT_CURSOR = 2'd0,
    IT_LETTER = 2'd1,
    IT_ACCID  = 2'd2,
    IT_OCTAVE = 2'd3
  } item_e;

  localparam item_e IT_LAST = IT_OCTAVE;

  localparam logic [7:0] CH_SHARP = 8'h23;
  localparam logic [7:0] CH_SPACE = 8'h20;
  localparam logic [7:0] CH_BAD   = 8'h3F;
  localparam logic [7:0] CH_A     = 8'h41;
  localparam logic [7:0] CH_ZERO  = 8'h30;

endpackage

// File: rtl/lcd_seq_rst_sync.sv
`timescale 1ns/1ps
module lcd_seq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/lcd_seq_pending.sv
`timescale 1ns/1ps
module lcd_seq_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);

  logic pend_q;
  logic pend_d;

  // A set in the same cycle as a clear wins: that pulse still needs its update.
  always_comb begin
    pend_d = set_i | (pend_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/lcd_seq_snap.sv
`timescale 1ns/1ps
module lcd_seq_snap #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else if (en_i) begin
      q_r <= d_i;
    end
  end

  assign q_o = q_r;

endmodule

// File: rtl/lcd_seq_fsm.sv
`timescale 1ns/1ps
module lcd_seq_fsm
  import lcd_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pend_i,
  input  logic  done_i,
  output logic  start_o,
  output logic  req_o,
  output logic  busy_o,
  output item_e item_o
);

  seq_state_e state_q, state_d;
  item_e      item_q, item_d;
  logic       start_c;

  always_comb begin
    state_d = state_q;
    item_d  = item_q;
    start_c = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (pend_i) begin
          start_c = 1'b1;
          state_d = ST_SEND;
          item_d  = IT_CURSOR;
        end
      end
      ST_SEND: begin
        if (done_i) begin
          if (item_q == IT_LAST) begin
            state_d = ST_IDLE;
          end else begin
            state_d = ST_GAP;
            item_d  = item_e'(item_q + 2'd1);
          end
        end
      end
      ST_GAP: begin
        state_d = ST_SEND;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      item_q  <= IT_CURSOR;
    end else begin
      state_q <= state_d;
      item_q  <= item_d;
    end
  end

  assign start_o = start_c;
  assign req_o   = (state_q == ST_SEND);
  assign busy_o  = (state_q != ST_IDLE);
  assign item_o  = item_q;

endmodule

// File: rtl/lcd_seq_encode.sv
`timescale 1ns/1ps
module lcd_seq_encode
  import lcd_seq_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned LETTER_W   = 3,
  parameter int unsigned OCT_W      = 4,
  parameter int unsigned N_LETTERS  = 7,
  parameter int unsigned MAX_DIGIT  = 9,
  parameter logic [7:0]  CURSOR_CMD = 8'h80
) (
  input  item_e               item_i,
  input  logic [LETTER_W-1:0] letter_i,
  input  logic                sharp_i,
  input  logic [OCT_W-1:0]    octave_i,
  output logic                rs_o,
  output logic [DATA_W-1:0]   data_o
);

  localparam int unsigned LETTER_SPAN = 1 << LETTER_W;
  localparam int unsigned OCT_SPAN    = 1 << OCT_W;

  logic letter_ok;
  logic octave_ok;
  logic [7:0] letter_ch;
  logic [7:0] accid_ch;
  logic [7:0] octave_ch;
  logic [7:0] byte_c;

  // Range checks only exist when the code space holds invalid values.
  generate
    if (N_LETTERS >= LETTER_SPAN) begin : g_letter_full
      assign letter_ok = 1'b1;
    end else begin : g_letter_range
      assign letter_ok = (32'(letter_i) < N_LETTERS);
    end
    if (MAX_DIGIT + 1 >= OCT_SPAN) begin : g_oct_full
      assign octave_ok = 1'b1;
    end else begin : g_oct_range
      assign octave_ok = (32'(octave_i) <= MAX_DIGIT);
    end
  endgenerate

  always_comb begin
    letter_ch = letter_ok ? (CH_A + 8'(letter_i)) : CH_BAD;
    accid_ch  = sharp_i ? CH_SHARP : CH_SPACE;
    octave_ch = octave_ok ? (CH_ZERO + 8'(octave_i)) : CH_BAD;
    rs_o      = 1'b1;
    unique case (item_i)
      IT_CURSOR: begin
        rs_o   = 1'b0;
        byte_c = CURSOR_CMD;
      end
      IT_LETTER: byte_c = letter_ch;
      IT_ACCID:  byte_c = accid_ch;
      IT_OCTAVE: byte_c = octave_ch;
      default:   byte_c = CH_BAD;
    endcase
    data_o = DATA_W'(byte_c);
  end

endmodule

// File: rtl/lcd_update_seq.sv
`timescale 1ns/1ps
module lcd_update_seq
  import lcd_seq_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned LETTER_W   = 3,
  parameter int unsigned OCT_W      = 4,
  parameter int unsigned N_LETTERS  = 7,
  parameter int unsigned MAX_DIGIT  = 9,
  parameter int unsigned RST_STAGES = 2,
  parameter logic [7:0]  CURSOR_CMD = 8'h80
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                data_ready_i,
  input  logic [LETTER_W-1:0] note_letter_i,
  input  logic                note_sharp_i,
  input  logic [OCT_W-1:0]    note_octave_i,
  output logic                drv_req_o,
  output logic                drv_rs_o,
  output logic [DATA_W-1:0]   drv_data_o,
  input  logic                drv_done_i
);

  localparam int unsigned SNAP_W = LETTER_W + 1 + OCT_W;

  logic              rst_sync_n;
  logic              pend_q;
  logic              start;
  logic              busy;
  item_e             item;
  logic [SNAP_W-1:0] snap_d;
  logic [SNAP_W-1:0] snap_q;

  lcd_seq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lcd_seq_pending u_pend (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_i  (data_ready_i),
    .clr_i  (start),
    .pend_o (pend_q)
  );

  assign snap_d = {note_letter_i, note_sharp_i, note_octave_i};

  lcd_seq_snap #(.W(SNAP_W)) u_snap (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en_i  (start),
    .d_i   (snap_d),
    .q_o   (snap_q)
  );

  lcd_seq_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .pend_i  (pend_q),
    .done_i  (drv_done_i),
    .start_o (start),
    .req_o   (drv_req_o),
    .busy_o  (busy),
    .item_o  (item)
  );

  lcd_seq_encode #(
    .DATA_W     (DATA_W),
    .LETTER_W   (LETTER_W),
    .OCT_W      (OCT_W),
    .N_LETTERS  (N_LETTERS),
    .MAX_DIGIT  (MAX_DIGIT),
    .CURSOR_CMD (CURSOR_CMD)
  ) u_enc (
    .item_i   (item),
    .letter_i (snap_q[SNAP_W-1 -: LETTER_W]),
    .sharp_i  (snap_q[OCT_W]),
    .octave_i (snap_q[OCT_W-1:0]),
    .rs_o     (drv_rs_o),
    .data_o   (drv_data_o)
  );

endmodule

// File: rtl/lcd_update_seq_chk.sv
`timescale 1ns/1ps
module lcd_update_seq_chk #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned SNAP_W     = 8,
  parameter logic [7:0]  CURSOR_CMD = 8'h80
) (
  input logic              clk,
  input logic              rst_n,
  input logic              data_ready_i,
  input logic              drv_req_o,
  input logic              drv_rs_o,
  input logic [DATA_W-1:0] drv_data_o,
  input logic              drv_done_i,
  input logic              pend_q,
  input logic              start,
  input logic              busy,
  input logic [SNAP_W-1:0] snap_q
);

  logic [1:0] n_items;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_items <= 2'd0;
    end else if (drv_req_o && drv_done_i) begin
      n_items <= n_items + 2'd1;
    end
  end

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !pend_q) |=> !drv_req_o);

  assert_cursor_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(drv_req_o) && n_items == 2'd0) |-> (!drv_rs_o && drv_data_o == DATA_W'(CURSOR_CMD)));

  assert_chars_rs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_req_o && n_items != 2'd0) |-> drv_rs_o);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_req_o && !drv_done_i) |=> (drv_req_o && $stable(drv_rs_o) && $stable(drv_data_o)));

  assert_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_req_o && drv_done_i) |=> !drv_req_o);

  assert_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready_i |=> pend_q);

  assert_snap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(snap_q));

  assert_start_from_pend_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(drv_req_o) && n_items == 2'd0) |-> $past(pend_q));

endmodule

bind lcd_update_seq lcd_update_seq_chk #(
  .DATA_W     (DATA_W),
  .SNAP_W     (SNAP_W),
  .CURSOR_CMD (CURSOR_CMD)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .data_ready_i (data_ready_i),
  .drv_req_o    (drv_req_o),
  .drv_rs_o     (drv_rs_o),
  .drv_data_o   (drv_data_o),
  .drv_done_i   (drv_done_i),
  .pend_q       (pend_q),
  .start        (start),
  .busy         (busy),
  .snap_q       (snap_q)
);

// File: tb/lcd_update_seq_test.sv
`timescale 1ns/1ps
module lcd_update_seq_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pulse;
  logic       done;
  logic [2:0] letter;
  logic       sharp;
  logic [3:0] oct;
  logic       req;
  logic       rs;
  logic [7:0] dout;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  lcd_update_seq uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .data_ready_i  (pulse),
    .note_letter_i (letter),
    .note_sharp_i  (sharp),
    .note_octave_i (oct),
    .drv_req_o     (req),
    .drv_rs_o      (rs),
    .drv_data_o    (dout),
    .drv_done_i    (done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic logic [7:0] exp_item(input int i, input logic [2:0] l,
                                          input logic s, input logic [3:0] o);
    case (i)
      0:       return 8'h80;
      1:       return (l < 3'd7) ? (8'h41 + 8'(l)) : 8'h3F;
      2:       return s ? 8'h23 : 8'h20;
      default: return (o <= 4'd9) ? (8'h30 + 8'(o)) : 8'h3F;
    endcase
  endfunction

  function automatic string item_tag(input int i);
    case (i)
      0:       return "R3";
      1:       return "R4";
      2:       return "R5";
      default: return "R6";
    endcase
  endfunction

  // Called at a falling edge while idle: drive note fields and a one-cycle pulse.
  task automatic start_update(input logic [2:0] l, input logic s, input logic [3:0] o);
    letter = l;
    sharp  = s;
    oct    = o;
    pulse  = 1'b1;
    @(negedge clk);
    pulse  = 1'b0;
    check(req === 1'b0, "R11", int'(req), 0);
  endtask

  // Acts as the display driver for one update and checks every item.
  task automatic serve(input logic [2:0] l, input logic s, input logic [3:0] o,
                       input int pa, input int pb, input int chg, input int maxd,
                       input string first_tag);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] e;
      int d;
      bit ok;
      e = exp_item(i, l, s, o);
      @(negedge clk);
      check(req === 1'b1, (i == 0) ? first_tag : "R7", int'(req), 1);
      if (req !== 1'b1) begin
        for (int w = 0; w < 40 && req !== 1'b1; w++) @(negedge clk);
        if (req !== 1'b1) return;
      end
      check(rs === (i != 0), "R3", int'(rs), int'(i != 0));
      check(dout === e, item_tag(i), int'(dout), int'(e));
      if (i == chg) begin
        letter = 3'($urandom_range(0, 7));
        sharp  = 1'($urandom_range(0, 1));
        oct    = 4'($urandom_range(0, 15));
      end
      d = $urandom_range(0, maxd);
      if ((i == pa || i == pb) && d == 0) d = 1;
      ok = 1'b1;
      for (int k = 0; k < d; k++) begin
        if (k == 0 && (i == pa || i == pb)) pulse = 1'b1;
        @(negedge clk);
        pulse = 1'b0;
        if (req !== 1'b1 || dout !== e) ok = 1'b0;
      end
      if (d > 0) check(ok, "R7", int'(dout), int'(e));
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
      check(req === 1'b0, "R7", int'(req), 0);
    end
  endtask

  task automatic idle_probe(input int cycles, input string tag);
    bit ok;
    ok = 1'b1;
    for (int k = 0; k < cycles; k++) begin
      done = 1'($urandom_range(0, 1));
      @(negedge clk);
      if (req !== 1'b0) ok = 1'b0;
    end
    done = 1'b0;
    check(ok, tag, int'(req), 0);
  endtask

  initial begin
    #3000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n  = 1'b0;
    pulse  = 1'b0;
    done   = 1'b0;
    letter = 3'd0;
    sharp  = 1'b0;
    oct    = 4'd0;
    repeat (3) @(negedge clk);
    check(req === 1'b0, "R1", int'(req), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req === 1'b0, "R1", int'(req), 0);

    // R2 and R8: stray done pulses while idle start nothing.
    idle_probe(20, "R8");

    // Directed boundary values of the letter and octave maps.
    start_update(3'd0, 1'b0, 4'd0);
    serve(3'd0, 1'b0, 4'd0, -1, -1, -1, 2, "R11");
    start_update(3'd6, 1'b1, 4'd9);
    serve(3'd6, 1'b1, 4'd9, -1, -1, -1, 0, "R11");
    start_update(3'd7, 1'b0, 4'd10);
    serve(3'd7, 1'b0, 4'd10, -1, -1, -1, 1, "R11");
    start_update(3'd3, 1'b1, 4'd15);
    serve(3'd3, 1'b1, 4'd15, -1, -1, -1, 3, "R11");
    idle_probe(5, "R2");

    // R10: inputs change at the first item; the old reading still prints.
    start_update(3'd2, 1'b1, 4'd4);
    serve(3'd2, 1'b1, 4'd4, -1, -1, 0, 2, "R11");
    idle_probe(4, "R2");

    // R9: two pulses during one update give exactly one extra update.
    start_update(3'd1, 1'b0, 4'd5);
    serve(3'd1, 1'b0, 4'd5, 1, 3, 2, 2, "R11");
    serve(letter, sharp, oct, -1, -1, -1, 2, "R9");
    idle_probe(6, "R9");

    // Constrained random updates.
    for (int n = 0; n < 40; n++) begin
      logic [2:0] l;
      logic s;
      logic [3:0] o;
      int pa, pb, chg;
      l   = 3'($urandom_range(0, 7));
      s   = 1'($urandom_range(0, 1));
      o   = 4'($urandom_range(0, 15));
      pa  = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 3)) : -1;
      pb  = (pa >= 0 && $urandom_range(0, 1) == 1) ? int'($urandom_range(0, 3)) : -1;
      chg = ($urandom_range(0, 1) == 1) ? int'($urandom_range(0, 3)) : -1;
      start_update(l, s, o);
      serve(l, s, o, pa, pb, chg, 4, "R11");
      if (pa >= 0) serve(letter, sharp, oct, -1, -1, -1, 3, "R9");
      idle_probe(3, (pa >= 0) ? "R9" : "R2");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule